// File: doc/BRIEF.md
# Two-Level Link Alarm Interrupt Aggregator

This block merges per-source fault indications from the receive and transmit directions into one active-low interrupt line that may be wired open-drain. There are three receive sources and three transmit sources: the physical-medium layer, the coding layer and the extender sublayer. Each source drives a sticky status bit. A per-source enable decides whether that bit contributes to its direction's summary. The two direction summaries and a sticky link-status alarm form a top-level status word. A second set of enables then decides which of those three bits may pull the interrupt line low.

Software reaches the block through a simple register port. A 3-bit select chooses the register, and a write strobe and a read strobe act on it. Read data is combinational from the select, so it shows the value before any clear that the read causes at the clock edge. Fault status bits stay set until their register is read while the source is inactive. A source that is still active during the read keeps its bit set.

Top module: `link_alarm_irq`

## Requirements
- R1: After reset the receive and transmit enable registers read 0x0019, the top enable register reads 0x0000, every status register reads 0x0000 and `irq_n_o` is 1.
- R2: Register selects are 0 for receive enables, 1 for transmit enables, 2 for top enables, 3 for receive status, 4 for transmit status and 5 for top status. In the receive and transmit enable registers only bits 4, 3 and 0 are writable. In the top enable register only bits 2:0 are writable. All other bits read 0.
- R3: Source index 0 (extender sublayer) maps to bit 0, index 1 (coding layer) to bit 3 and index 2 (physical medium) to bit 4 of its enable and status registers. A fault input high at a clock edge sets its status bit, and the bit remains set after the input falls.
- R4: Reading a receive or transmit status register returns the value held before the read. The read clears every bit whose fault input is low at that edge. A bit whose input is still high stays set.
- R5: Reading any other register leaves the status bits unchanged. A write to a status register leaves the status bits unchanged.
- R6: Top status bit 2 is the OR of the receive status bits whose enables are set. Bit 1 is the same for the transmit side. Both follow their inputs with no latching of their own.
- R7: Top status bit 0 latches `link_alarm_i` and clears on a read of the top status register when the input is low. Top status bit 3 shows `host_grant_i` directly.
- R8: `irq_n_o` is 0 exactly when some top status bit in 2:0 and the matching top enable bit are both 1. Otherwise it is 1.
- R9: Selects 6 and 7 read 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_sel | input | 3 | Register select |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe (clear-on-read side effect) |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for the selected register |
| rx_fault_i | input | 3 | Receive fault sources, index order per R3 |
| tx_fault_i | input | 3 | Transmit fault sources, index order per R3 |
| link_alarm_i | input | 1 | Link-status alarm source |
| host_grant_i | input | 1 | Host-control grant indication |
| irq_n_o | output | 1 | Active-low interrupt, low drives the open-drain pad |

## Verification
Several properties are checked on every cycle. A status bank holds its value when it is not read and no fault is active. A status read with no active fault empties the bank. Any active fault leaves at least one bit set on the next cycle. The interrupt stays high while all top enables are clear. The bench is the only place that shows bit positions, writable-bit masks and the value returned by a read. It also sweeps every enable mask against every fault pattern on both sides, which demonstrates the two-level gating and the rule that an active source survives a read.

// File: rtl/link_alarm_pkg.sv
package link_alarm_pkg;
  localparam int REG_W  = 16;
  localparam int ADDR_W = 3;
  localparam int NSRC   = 3;

  localparam int SEL_RX_CTRL  = 0;
  localparam int SEL_TX_CTRL  = 1;
  localparam int SEL_TOP_CTRL = 2;
  localparam int SEL_RX_STAT  = 3;
  localparam int SEL_TX_STAT  = 4;
  localparam int SEL_TOP_STAT = 5;

  localparam int TOP_LINK  = 0;
  localparam int TOP_TX    = 1;
  localparam int TOP_RX    = 2;
  localparam int TOP_GRANT = 3;
  localparam int TOP_N     = 3;

  // source index -> bit position inside enable/status words
  function automatic int src_bit(input int idx);
    case (idx)
      0:       return 0;
      1:       return 3;
      default: return 4;
    endcase
  endfunction
endpackage

// File: rtl/sticky_bits.sv
module sticky_bits #(
  parameter int N = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic         clr_i,
  output logic [N-1:0] q_o
);
  logic [N-1:0] q_d;
  logic         q_en;

  always_comb begin
    q_en = clr_i | (|set_i);
    q_d  = set_i | (clr_i ? '0 : q_o);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      q_o <= '0;
    else if (q_en)
      q_o <= q_d;
  end
endmodule

// File: rtl/alarm_bank.sv
module alarm_bank
  import link_alarm_pkg::*;
#(
  parameter int W  = REG_W,
  parameter int NS = NSRC
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctrl_we,
  input  logic [W-1:0]  wdata,
  input  logic          stat_re,
  input  logic [NS-1:0] fault_i,
  output logic [W-1:0]  ctrl_word,
  output logic [W-1:0]  stat_word,
  output logic          summary_o
);
  logic [NS-1:0] en_q;
  logic [NS-1:0] en_d;
  logic [NS-1:0] wr_bits;
  logic [NS-1:0] stat_q;

  always_comb begin
    for (int i = 0; i < NS; i++)
      wr_bits[i] = wdata[src_bit(i)];
    en_d = ctrl_we ? wr_bits : en_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      en_q <= '1;
    else if (ctrl_we)
      en_q <= en_d;
  end

  sticky_bits #(.N(NS)) u_stat (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (fault_i),
    .clr_i (stat_re),
    .q_o   (stat_q)
  );

  always_comb begin
    ctrl_word = '0;
    stat_word = '0;
    for (int i = 0; i < NS; i++) begin
      ctrl_word[src_bit(i)] = en_q[i];
      stat_word[src_bit(i)] = stat_q[i];
    end
    summary_o = |(en_q & stat_q);
  end
endmodule

// File: rtl/link_alarm_irq.sv
module link_alarm_irq
  import link_alarm_pkg::*;
#(
  parameter int W  = REG_W,
  parameter int AW = ADDR_W,
  parameter int NS = NSRC
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] reg_sel,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [W-1:0]  reg_wdata,
  output logic [W-1:0]  reg_rdata,
  input  logic [NS-1:0] rx_fault_i,
  input  logic [NS-1:0] tx_fault_i,
  input  logic          link_alarm_i,
  input  logic          host_grant_i,
  output logic          irq_n_o
);
  logic rst_meta, rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  logic we_rx, we_tx, we_top, re_rx, re_tx, re_top;

  always_comb begin
    we_rx  = reg_wr && (reg_sel == AW'(SEL_RX_CTRL));
    we_tx  = reg_wr && (reg_sel == AW'(SEL_TX_CTRL));
    we_top = reg_wr && (reg_sel == AW'(SEL_TOP_CTRL));
    re_rx  = reg_rd && (reg_sel == AW'(SEL_RX_STAT));
    re_tx  = reg_rd && (reg_sel == AW'(SEL_TX_STAT));
    re_top = reg_rd && (reg_sel == AW'(SEL_TOP_STAT));
  end

  logic [W-1:0] rx_ctrl_word, rx_stat_word, tx_ctrl_word, tx_stat_word;
  logic         rx_sum, tx_sum;

  alarm_bank #(.W(W), .NS(NS)) u_rx (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .ctrl_we   (we_rx),
    .wdata     (reg_wdata),
    .stat_re   (re_rx),
    .fault_i   (rx_fault_i),
    .ctrl_word (rx_ctrl_word),
    .stat_word (rx_stat_word),
    .summary_o (rx_sum)
  );

  alarm_bank #(.W(W), .NS(NS)) u_tx (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .ctrl_we   (we_tx),
    .wdata     (reg_wdata),
    .stat_re   (re_tx),
    .fault_i   (tx_fault_i),
    .ctrl_word (tx_ctrl_word),
    .stat_word (tx_stat_word),
    .summary_o (tx_sum)
  );

  logic [TOP_N-1:0] top_ctrl_q, top_ctrl_d;

  always_comb top_ctrl_d = we_top ? reg_wdata[TOP_N-1:0] : top_ctrl_q;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)
      top_ctrl_q <= '0;
    else if (we_top)
      top_ctrl_q <= top_ctrl_d;
  end

  logic link_q;

  sticky_bits #(.N(1)) u_link (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .set_i (link_alarm_i),
    .clr_i (re_top),
    .q_o   (link_q)
  );

  logic [TOP_N-1:0] top_alarm;
  logic [W-1:0]     top_stat_word, top_ctrl_word;

  always_comb begin
    top_alarm           = '0;
    top_alarm[TOP_RX]   = rx_sum;
    top_alarm[TOP_TX]   = tx_sum;
    top_alarm[TOP_LINK] = link_q;
    top_stat_word            = '0;
    top_stat_word[TOP_N-1:0] = top_alarm;
    top_stat_word[TOP_GRANT] = host_grant_i;
    top_ctrl_word            = '0;
    top_ctrl_word[TOP_N-1:0] = top_ctrl_q;
  end

  always_comb begin
    case (reg_sel)
      AW'(SEL_RX_CTRL):  reg_rdata = rx_ctrl_word;
      AW'(SEL_TX_CTRL):  reg_rdata = tx_ctrl_word;
      AW'(SEL_TOP_CTRL): reg_rdata = top_ctrl_word;
      AW'(SEL_RX_STAT):  reg_rdata = rx_stat_word;
      AW'(SEL_TX_STAT):  reg_rdata = tx_stat_word;
      AW'(SEL_TOP_STAT): reg_rdata = top_stat_word;
      default:           reg_rdata = '0;
    endcase
  end

  assign irq_n_o = ~|(top_alarm & top_ctrl_q);
endmodule

// File: rtl/link_alarm_chk.sv
module link_alarm_chk
  import link_alarm_pkg::*;
#(
  parameter int W  = REG_W,
  parameter int AW = ADDR_W,
  parameter int NS = NSRC
) (
  input logic             clk,
  input logic             rst_n,
  input logic [AW-1:0]    reg_sel,
  input logic             reg_rd,
  input logic [NS-1:0]    rx_fault_i,
  input logic [NS-1:0]    tx_fault_i,
  input logic [W-1:0]     rx_stat,
  input logic [W-1:0]     tx_stat,
  input logic [TOP_N-1:0] top_ctrl,
  input logic             irq_n
);
  logic rd_rx, rd_tx;
  assign rd_rx = reg_rd && (reg_sel == AW'(SEL_RX_STAT));
  assign rd_tx = reg_rd && (reg_sel == AW'(SEL_TX_STAT));

  assert_rx_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_rx && rx_fault_i == '0) |=> (rx_stat == $past(rx_stat)));

  assert_tx_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_tx && tx_fault_i == '0) |=> (tx_stat == $past(tx_stat)));

  assert_rx_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_rx && rx_fault_i == '0) |=> (rx_stat == '0));

  assert_tx_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_fault_i != '0) |=> (tx_stat != '0));

  assert_rx_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_fault_i != '0) |=> (rx_stat != '0));

  assert_irq_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (top_ctrl == '0) |-> irq_n);
endmodule

bind link_alarm_irq link_alarm_chk #(.W(W), .AW(AW), .NS(NS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .reg_sel    (reg_sel),
  .reg_rd     (reg_rd),
  .rx_fault_i (rx_fault_i),
  .tx_fault_i (tx_fault_i),
  .rx_stat    (rx_stat_word),
  .tx_stat    (tx_stat_word),
  .top_ctrl   (top_ctrl_q),
  .irq_n      (irq_n_o)
);

// File: tb/sim_link_alarm_irq.sv
`timescale 1ns/1ps
module sim_link_alarm_irq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  reg_sel = '0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic [2:0]  rx_fault_i = '0, tx_fault_i = '0;
  logic        link_alarm_i = 1'b0, host_grant_i = 1'b0;
  logic        irq_n_o;

  int vec = 0;
  int bad = 0;

  always #10 clk = ~clk;

  link_alarm_irq u0 (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .rx_fault_i(rx_fault_i), .tx_fault_i(tx_fault_i),
    .link_alarm_i(link_alarm_i), .host_grant_i(host_grant_i),
    .irq_n_o(irq_n_o)
  );

  function automatic int bpos(input int i);
    if (i == 0) return 0;
    else if (i == 1) return 3;
    return 4;
  endfunction

  function automatic logic [15:0] spread(input logic [2:0] m);
    logic [15:0] w = '0;
    for (int i = 0; i < 3; i++) if (m[i]) w = w | (16'h1 << bpos(i));
    return w;
  endfunction

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    vec++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input int sel, input logic [15:0] d);
    @(negedge clk);
    reg_sel = 3'(sel); reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input int sel, output logic [15:0] d);
    @(negedge clk);
    reg_sel = 3'(sel); reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic peek(input int sel, output logic [15:0] d);
    @(negedge clk);
    reg_sel = 3'(sel);
    #1 d = reg_rdata;
  endtask

  task automatic pulse(input int bank, input logic [2:0] f);
    @(negedge clk);
    if (bank == 0) rx_fault_i = f; else tx_fault_i = f;
    @(negedge clk);
    rx_fault_i = '0; tx_fault_i = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  initial begin
    logic [15:0] d;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state, R9 unmapped selects
    peek(0, d); chk("R1 rx_ctrl", d, 16'h0019);
    peek(1, d); chk("R1 tx_ctrl", d, 16'h0019);
    peek(2, d); chk("R1 top_ctrl", d, 16'h0000);
    peek(3, d); chk("R1 rx_stat", d, 16'h0000);
    peek(4, d); chk("R1 tx_stat", d, 16'h0000);
    peek(5, d); chk("R1 top_stat", d, 16'h0000);
    chk("R1 irq_n", {15'h0, irq_n_o}, 16'h1);
    peek(6, d); chk("R9 sel6", d, 16'h0000);
    peek(7, d); chk("R9 sel7", d, 16'h0000);

    // R2 writable masks
    wr(0, 16'hFFFF); peek(0, d); chk("R2 rx_ctrl ones", d, 16'h0019);
    wr(0, 16'h0000); peek(0, d); chk("R2 rx_ctrl zero", d, 16'h0000);
    wr(1, 16'hFFE6); peek(1, d); chk("R2 tx_ctrl resv", d, 16'h0000);
    wr(2, 16'hFFFF); peek(2, d); chk("R2 top_ctrl ones", d, 16'h0007);
    wr(2, 16'h0000); wr(0, 16'h0019); wr(1, 16'h0019);

    // R3/R4/R5 per-source sweep on both sides
    for (int b = 0; b < 2; b++) begin
      for (int i = 0; i < 3; i++) begin
        pulse(b, 3'(1 << i));
        peek(3 + b, d); chk("R3 latch", d, 16'h1 << bpos(i));
        rd(0, d); rd(5, d); wr(3 + b, 16'h0000);
        peek(3 + b, d); chk("R5 other read/write kept", d, 16'h1 << bpos(i));
        rd(3 + b, d); chk("R4 read value", d, 16'h1 << bpos(i));
        peek(3 + b, d); chk("R4 cleared", d, 16'h0000);
        // source still active during read
        @(negedge clk);
        if (b == 0) rx_fault_i = 3'(1 << i); else tx_fault_i = 3'(1 << i);
        @(negedge clk);
        reg_sel = 3'(3 + b); reg_rd = 1'b1;
        @(negedge clk);
        reg_rd = 1'b0; rx_fault_i = '0; tx_fault_i = '0;
        peek(3 + b, d); chk("R4 active survives read", d, 16'h1 << bpos(i));
        rd(3 + b, d); peek(3 + b, d); chk("R4 clear after drop", d, 16'h0000);
      end
    end

    // R5 write to status with bits set
    pulse(0, 3'b111); wr(3, 16'h0000); peek(3, d);
    chk("R5 status write ignored", d, 16'h0019);
    rd(3, d);

    // R6/R8 enable mask x fault pattern sweep
    for (int b = 0; b < 2; b++) begin
      for (int m = 0; m < 8; m++) begin
        for (int f = 1; f < 8; f++) begin
          logic hit;
          hit = |(3'(m) & 3'(f));
          wr(b, spread(3'(m)));
          wr(2, (b == 0) ? 16'h4 : 16'h2);
          pulse(b, 3'(f));
          peek(5, d);
          chk("R6 summary", d, (b == 0) ? {13'h0, hit, 2'b00} : {14'h0, hit, 1'b0});
          chk("R8 irq gate", {15'h0, irq_n_o}, {15'h0, ~hit});
          wr(2, (b == 0) ? 16'h2 : 16'h4);
          chk("R8 other enable", {15'h0, irq_n_o}, 16'h1);
          rd(3 + b, d);
        end
      end
    end
    wr(0, 16'h0019); wr(1, 16'h0019); wr(2, 16'h0000);

    // R7 link alarm and grant
    @(negedge clk) link_alarm_i = 1'b1;
    @(negedge clk) link_alarm_i = 1'b0;
    peek(5, d); chk("R7 link latched", d, 16'h0001);
    chk("R8 link masked", {15'h0, irq_n_o}, 16'h1);
    wr(2, 16'h0001);
    chk("R8 link enabled", {15'h0, irq_n_o}, 16'h0);
    rd(3, d); peek(5, d); chk("R7 rx read keeps link", d, 16'h0001);
    rd(5, d); chk("R7 read value", d, 16'h0001);
    peek(5, d); chk("R7 link cleared", d, 16'h0000);
    chk("R8 released", {15'h0, irq_n_o}, 16'h1);
    @(negedge clk) host_grant_i = 1'b1;
    peek(5, d); chk("R7 grant high", d, 16'h0008);
    @(negedge clk) host_grant_i = 1'b0;
    peek(5, d); chk("R7 grant low", d, 16'h0000);

    $display("  == %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule